// File: doc/BRIEF.md
# Packed Host/Engine Byte Buffer

This block sits between a host data register that is 16 bits wide and a serial bus engine that moves one byte at a time. It holds up to four bytes in numbered lanes. The fill count is the number of occupied lanes. Occupied lanes are always the lowest ones, and every lane at or above the count holds zero.

A host write can place two bytes at once. It can also place one byte, which is meant for the final odd byte of a transfer. A control input selects the byte order used between the 16-bit host word and the lanes. The engine pops bytes from the top of the buffer for transmit and appends received bytes above the current fill. Host reads take two bytes at a time from the bottom lanes.

Sticky flags report four conditions: a transmit underflow, a receive overrun, a read that found only one byte, and the ready state of each direction. The serial protocol itself is handled elsewhere.

Top module: `packed_data_buffer`

## Requirements
- R1: A synchronous reset clears the fill count, every flag, `host_rdata` and `eng_tx_data`.
- R2: At most one operation takes effect in a clock cycle. The priority order is receive push, then transmit pop, then host write, then host read. Any lower-priority strobe raised in the same cycle is ignored.
- R3: A receive push below full stores the byte in lane `fill_count`, adds one to the count and sets `flag_rx_ready`. A receive push at full (count 4) drops the byte, leaves the lanes and the count unchanged, and sets `flag_overrun`.
- R4: A transmit pop with a non-zero count presents the byte from lane `fill_count-1` on `eng_tx_data` one cycle later and lowers the count by one. If the pop empties the buffer, `flag_tx_ready` is set.
- R5: A transmit pop on an empty buffer sets `flag_underflow` and `flag_tx_ready`, drives `eng_tx_data` to zero and leaves the count at zero.
- R6: A 16-bit host write (`host_byte`=0) with count at most 2 moves the existing bytes up two lanes and adds two to the count. With `be_mode`=1, `host_wdata[15:8]` goes to lane 1 and `host_wdata[7:0]` goes to lane 0. With `be_mode`=0 these two bytes swap lanes. The write is ignored when the count is 3 or 4.
- R7: An 8-bit host write (`host_byte`=1) below full moves the existing bytes up one lane, puts `host_wdata[7:0]` in lane 0 and adds one to the count. It is ignored at full.
- R8: A host read with count at least 2 returns lanes 0 and 1 on `host_rdata` one cycle later. With `be_mode`=1 the word is {lane0, lane1}; with `be_mode`=0 it is {lane1, lane0}. The remaining bytes move down two lanes and the count drops by two.
- R9: A host read with count 1 returns lane 0 combined with a zero byte in the same order as R8, empties the buffer and sets `flag_single`. A read with any other count clears `flag_single`. A read on an empty buffer returns zero.
- R10: Any host write, accepted or ignored, clears `flag_underflow` and `flag_tx_ready`. Any host read clears `flag_rx_ready` and `flag_overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| be_mode | input | 1 | Byte order: 1 puts the upper host byte in lane 1 |
| host_wr | input | 1 | Host data write strobe |
| host_byte | input | 1 | Qualifies a write as a single byte |
| host_wdata | input | 16 | Host write data |
| host_rd | input | 1 | Host data read strobe |
| host_rdata | output | 16 | Registered host read word |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_tx_pop | input | 1 | Engine requests a byte to send |
| eng_tx_data | output | 8 | Registered byte for the engine |
| fill_count | output | 3 | Number of occupied lanes (0 to 4) |
| flag_underflow | output | 1 | Sticky: pop from an empty buffer |
| flag_overrun | output | 1 | Sticky: push into a full buffer |
| flag_single | output | 1 | Last read found a single byte |
| flag_rx_ready | output | 1 | Sticky: a received byte was stored |
| flag_tx_ready | output | 1 | Sticky: transmit side needs data |

## Verification
The bench targets several corner cases that a faulty design would get wrong in a visible way:
- Pushes and writes at the full and near-full boundaries. A design with a wrong bound would wrap the count or overwrite the lane holding the oldest byte.
- Reads at count 1 and count 0. A design that did not clear the stale lane would return leftover data in the spare byte, or would miss `flag_single`.
- Both byte orders on the write and read sides. A swap in either direction would reverse the transmit byte sequence.
- All four strobes raised in the same cycle. A design with the wrong priority would apply two operations at once or move the wrong bytes.

A long run of mixed random strobes is compared against a queue model on every cycle.

// File: rtl/hbuf_pkg.sv
package hbuf_pkg;
  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_RX   = 3'd1,
    OP_TX   = 3'd2,
    OP_WR2  = 3'd3,
    OP_WR1  = 3'd4,
    OP_RD   = 3'd5
  } hbuf_op_e;
endpackage

// File: rtl/hbuf_order.sv
module hbuf_order #(
  parameter int BW = 8
) (
  input  logic          be,
  input  logic [2*BW-1:0] wdata,
  input  logic [BW-1:0] lane0,
  input  logic [BW-1:0] lane1,
  output logic [BW-1:0] wr_l1,
  output logic [BW-1:0] wr_l0,
  output logic [2*BW-1:0] rd_word
);
  assign wr_l1   = be ? wdata[2*BW-1:BW] : wdata[BW-1:0];
  assign wr_l0   = be ? wdata[BW-1:0]    : wdata[2*BW-1:BW];
  assign rd_word = be ? {lane0, lane1}   : {lane1, lane0};
endmodule

// File: rtl/hbuf_lanes.sv
module hbuf_lanes import hbuf_pkg::*; #(
  parameter int LANES = 4,
  parameter int BW    = 8,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  hbuf_op_e        op,
  input  logic [BW-1:0]   wr_l1,
  input  logic [BW-1:0]   wr_l0,
  input  logic [BW-1:0]   wr_b,
  input  logic [BW-1:0]   rx_byte,
  input  logic [2*BW-1:0] rd_word,
  output logic [BW-1:0]   lane0,
  output logic [BW-1:0]   lane1,
  output logic [CW-1:0]   cnt,
  output logic [BW-1:0]   tx_q,
  output logic [2*BW-1:0] rd_q
);
  localparam logic [CW-1:0] FULL = CW'(LANES);
  localparam logic [CW-1:0] ROOM2 = CW'(LANES - 2);

  logic [BW-1:0] mem [LANES];

  assign lane0 = mem[0];
  assign lane1 = mem[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LANES; i++) mem[i] <= '0;
      cnt  <= '0;
      tx_q <= '0;
      rd_q <= '0;
    end else begin
      case (op)
        OP_RX: begin
          if (cnt != FULL) begin
            for (int i = 0; i < LANES; i++)
              if (CW'(i) == cnt) mem[i] <= rx_byte;
            cnt <= cnt + 1'b1;
          end
        end
        OP_TX: begin
          if (cnt != '0) begin
            for (int i = 0; i < LANES; i++)
              if (CW'(i) == cnt - 1'b1) begin
                tx_q   <= mem[i];
                mem[i] <= '0;
              end
            cnt <= cnt - 1'b1;
          end else begin
            tx_q <= '0;
          end
        end
        OP_WR2: begin
          if (cnt <= ROOM2) begin
            for (int i = 2; i < LANES; i++) mem[i] <= mem[i-2];
            mem[1] <= wr_l1;
            mem[0] <= wr_l0;
            cnt    <= cnt + CW'(2);
          end
        end
        OP_WR1: begin
          if (cnt != FULL) begin
            for (int i = 1; i < LANES; i++) mem[i] <= mem[i-1];
            mem[0] <= wr_b;
            cnt    <= cnt + 1'b1;
          end
        end
        OP_RD: begin
          rd_q <= rd_word;
          if (cnt >= CW'(2)) begin
            for (int i = 0; i < LANES - 2; i++) mem[i] <= mem[i+2];
            mem[LANES-2] <= '0;
            mem[LANES-1] <= '0;
            cnt <= cnt - CW'(2);
          end else begin
            mem[0] <= '0;
            cnt    <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);
  p_rx_full_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RX && cnt == FULL) |=> (cnt == FULL && $stable(lane0)));
  p_tx_dec_r4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_TX && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  p_tx_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_TX && cnt == '0) |=> (cnt == '0 && tx_q == '0));
  p_wr2_noroom_r6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_WR2 && cnt > ROOM2) |=> $stable(cnt));
  p_wr1_full_r7: assert property (@(posedge clk) disable iff (rst)
    (op == OP_WR1 && cnt == FULL) |=> $stable(cnt));

  for (genvar g = 0; g < LANES; g++) begin : g_idle_chk
    p_idle_lane_zero_r9: assert property (@(posedge clk) disable iff (rst)
      (CW'(g) >= cnt) |-> (mem[g] == '0));
  end
endmodule

// File: rtl/hbuf_flags.sv
module hbuf_flags import hbuf_pkg::*; #(
  parameter int LANES = 4,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  hbuf_op_e      op,
  input  logic [CW-1:0] cnt,
  output logic          xudf,
  output logic          rovr,
  output logic          sbd,
  output logic          rrdy,
  output logic          xrdy
);
  localparam logic [CW-1:0] FULL = CW'(LANES);

  always_ff @(posedge clk) begin
    if (rst) begin
      xudf <= 1'b0;
      rovr <= 1'b0;
      sbd  <= 1'b0;
      rrdy <= 1'b0;
      xrdy <= 1'b0;
    end else begin
      case (op)
        OP_RX: begin
          if (cnt == FULL) rovr <= 1'b1;
          else             rrdy <= 1'b1;
        end
        OP_TX: begin
          if (cnt == '0) xudf <= 1'b1;
          if (cnt <= CW'(1)) xrdy <= 1'b1;
        end
        OP_WR2, OP_WR1: begin
          xudf <= 1'b0;
          xrdy <= 1'b0;
        end
        OP_RD: begin
          rrdy <= 1'b0;
          rovr <= 1'b0;
          sbd  <= (cnt == CW'(1));
        end
        default: ;
      endcase
    end
  end

  p_rd_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RD) |=> (!rrdy && !rovr));
  p_wr_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (op == OP_WR2 || op == OP_WR1) |=> (!xudf && !xrdy));
  p_single_set_r9: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RD && cnt == CW'(1)) |=> sbd);
  p_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_TX && cnt == '0) |=> (xudf && xrdy));
endmodule

// File: rtl/packed_data_buffer.sv
module packed_data_buffer import hbuf_pkg::*; #(
  parameter int LANES = 4,
  parameter int BW    = 8,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            be_mode,
  input  logic            host_wr,
  input  logic            host_byte,
  input  logic [2*BW-1:0] host_wdata,
  input  logic            host_rd,
  output logic [2*BW-1:0] host_rdata,
  input  logic            eng_rx_push,
  input  logic [BW-1:0]   eng_rx_data,
  input  logic            eng_tx_pop,
  output logic [BW-1:0]   eng_tx_data,
  output logic [CW-1:0]   fill_count,
  output logic            flag_underflow,
  output logic            flag_overrun,
  output logic            flag_single,
  output logic            flag_rx_ready,
  output logic            flag_tx_ready
);
  hbuf_op_e        op;
  logic [BW-1:0]   wr_l1, wr_l0, lane0, lane1;
  logic [2*BW-1:0] rd_word;

  // R2: single operation per cycle, fixed priority
  always_comb begin
    if (eng_rx_push)     op = OP_RX;
    else if (eng_tx_pop) op = OP_TX;
    else if (host_wr)    op = host_byte ? OP_WR1 : OP_WR2;
    else if (host_rd)    op = OP_RD;
    else                 op = OP_IDLE;
  end

  hbuf_order #(.BW(BW)) u_order (
    .be(be_mode), .wdata(host_wdata), .lane0(lane0), .lane1(lane1),
    .wr_l1(wr_l1), .wr_l0(wr_l0), .rd_word(rd_word)
  );

  hbuf_lanes #(.LANES(LANES), .BW(BW)) u_lanes (
    .clk(clk), .rst(rst), .op(op), .wr_l1(wr_l1), .wr_l0(wr_l0),
    .wr_b(host_wdata[BW-1:0]), .rx_byte(eng_rx_data), .rd_word(rd_word),
    .lane0(lane0), .lane1(lane1), .cnt(fill_count), .tx_q(eng_tx_data),
    .rd_q(host_rdata)
  );

  hbuf_flags #(.LANES(LANES)) u_flags (
    .clk(clk), .rst(rst), .op(op), .cnt(fill_count),
    .xudf(flag_underflow), .rovr(flag_overrun), .sbd(flag_single),
    .rrdy(flag_rx_ready), .xrdy(flag_tx_ready)
  );
endmodule

// File: tb/packed_data_buffer_tb.sv
module packed_data_buffer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        be_mode = 1'b0, host_wr = 1'b0, host_byte = 1'b0, host_rd = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        eng_rx_push = 1'b0, eng_tx_pop = 1'b0;
  logic [7:0]  eng_rx_data = '0;
  logic [7:0]  eng_tx_data;
  logic [2:0]  fill_count;
  logic        flag_underflow, flag_overrun, flag_single, flag_rx_ready, flag_tx_ready;

  always #10 clk = ~clk;

  packed_data_buffer u_dut (
    .clk(clk), .rst(rst), .be_mode(be_mode), .host_wr(host_wr),
    .host_byte(host_byte), .host_wdata(host_wdata), .host_rd(host_rd),
    .host_rdata(host_rdata), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .eng_tx_pop(eng_tx_pop),
    .eng_tx_data(eng_tx_data), .fill_count(fill_count),
    .flag_underflow(flag_underflow), .flag_overrun(flag_overrun),
    .flag_single(flag_single), .flag_rx_ready(flag_rx_ready),
    .flag_tx_ready(flag_tx_ready)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0]  mq[$];
  logic [15:0] m_rd = '0;
  logic [7:0]  m_tx = '0;
  bit m_xudf = 0, m_rovr = 0, m_sbd = 0, m_rrdy = 0, m_xrdy = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(req, "fill_count", int'(fill_count), mq.size());
    chk(req, "host_rdata", int'(host_rdata), int'(m_rd));
    chk(req, "eng_tx_data", int'(eng_tx_data), int'(m_tx));
    chk(req, "flags", int'({flag_underflow, flag_overrun, flag_single, flag_rx_ready, flag_tx_ready}),
        int'({m_xudf, m_rovr, m_sbd, m_rrdy, m_xrdy}));
  endtask

  task automatic step(input bit rx, input bit tx, input bit wr, input bit wb, input bit rd,
                      input bit be, input logic [15:0] wd, input logic [7:0] rb, input string req);
    logic [7:0] b0, b1;
    eng_rx_push = rx; eng_tx_pop = tx; host_wr = wr; host_byte = wb; host_rd = rd;
    be_mode = be; host_wdata = wd; eng_rx_data = rb;
    if (rx) begin
      if (mq.size() == 4) m_rovr = 1;
      else begin mq.push_back(rb); m_rrdy = 1; end
    end else if (tx) begin
      if (mq.size() == 0) begin m_xudf = 1; m_xrdy = 1; m_tx = 8'h00; end
      else begin m_tx = mq.pop_back(); if (mq.size() == 0) m_xrdy = 1; end
    end else if (wr) begin
      m_xudf = 0; m_xrdy = 0;
      if (wb) begin
        if (mq.size() < 4) mq.push_front(wd[7:0]);
      end else if (mq.size() <= 2) begin
        mq.push_front(be ? wd[15:8] : wd[7:0]);
        mq.push_front(be ? wd[7:0] : wd[15:8]);
      end
    end else if (rd) begin
      m_rrdy = 0; m_rovr = 0;
      m_sbd = (mq.size() == 1);
      b0 = (mq.size() > 0) ? mq[0] : 8'h00;
      b1 = (mq.size() > 1) ? mq[1] : 8'h00;
      m_rd = be ? {b0, b1} : {b1, b0};
      if (mq.size() > 0) void'(mq.pop_front());
      if (mq.size() > 0 && !m_sbd) void'(mq.pop_front());
    end
    @(posedge clk); #2;
    compare(req);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    compare("R1");
    rst = 1'b0;

    // R3: receive fill and overrun at full
    step(1,0,0,0,0,1,16'h0,8'h11,"R3");
    step(1,0,0,0,0,1,16'h0,8'h22,"R3");
    step(1,0,0,0,0,1,16'h0,8'h33,"R3");
    step(1,0,0,0,0,1,16'h0,8'h44,"R3");
    step(1,0,0,0,0,1,16'h0,8'h55,"R3");
    // R8: reads in both byte orders
    step(0,0,0,0,1,1,16'h0,8'h0,"R8");
    step(0,0,0,0,1,0,16'h0,8'h0,"R8");
    // R9: empty read, then single-byte read
    step(0,0,0,0,1,0,16'h0,8'h0,"R9");
    step(1,0,0,0,0,0,16'h0,8'h66,"R3");
    step(0,0,0,0,1,0,16'h0,8'h0,"R9");
    step(1,0,0,0,0,0,16'h0,8'h77,"R3");
    step(0,0,0,0,1,1,16'h0,8'h0,"R9");
    // R6 / R4: writes in both orders, then drain by pops
    step(0,0,1,0,0,1,16'hA1B2,8'h0,"R6");
    step(0,0,1,0,0,0,16'hC3D4,8'h0,"R6");
    step(0,1,0,0,0,0,16'h0,8'h0,"R4");
    step(0,1,0,0,0,0,16'h0,8'h0,"R4");
    step(0,1,0,0,0,0,16'h0,8'h0,"R4");
    step(0,1,0,0,0,0,16'h0,8'h0,"R4");
    // R5: pop from empty, then R10 write clears
    step(0,1,0,0,0,0,16'h0,8'h0,"R5");
    step(0,0,1,1,0,0,16'h00E5,8'h0,"R10");
    // R6 / R7: boundaries of room
    step(0,0,1,0,0,1,16'h1234,8'h0,"R6");
    step(0,0,1,0,0,1,16'h5678,8'h0,"R6");
    step(0,0,1,1,0,0,16'hFF9A,8'h0,"R7");
    step(0,0,1,1,0,0,16'h00BC,8'h0,"R7");
    step(0,0,0,0,1,1,16'h0,8'h0,"R8");
    step(0,0,0,0,1,1,16'h0,8'h0,"R8");
    // R2: simultaneous strobes
    step(1,1,1,0,1,1,16'hDEAD,8'hC1,"R2");
    step(0,1,1,0,1,1,16'hBEEF,8'h0,"R2");
    step(0,0,1,0,1,0,16'h4321,8'h0,"R2");
    step(0,0,0,0,1,0,16'h0,8'h0,"R10");

    // mixed traffic against the queue model
    for (int n = 0; n < 600; n++) begin
      automatic int unsigned r = $urandom;
      step(r[2:0] == 3'd0, r[5:3] == 3'd0, r[7:6] == 2'd0, r[8], r[10:9] != 2'd0,
           r[11], r[27:12], r[31:24], "R2");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule